// File: doc/BRIEF.md
# Serial Converter Power-Mode Frame Engine

This block is the device-side digital logic of a serial analog-to-digital converter. A host frames each transfer with an active-low chip select and sixteen serial clock pulses. During a frame the block shifts in a 16-bit command word and shifts out a 16-bit result frame. The result frame carries a zero start bit, the 3-bit channel tag and a 12-bit result, which the model takes from a test input at the start of the frame. The leading 12 command bits feed a control register that holds a write-enable, a channel address and two power-mode bits. The whole 16-bit word feeds a shadow register.

The block follows the converter's power state across active, full power-down and auto power-down, and a power-up timer runs whenever the part wakes. It decides frame by frame whether the data output is driven and when the track/hold leaves hold. A wake from full power-down begins when chip select rises at the end of the frame that programs active mode. A wake from auto power-down begins when chip select falls. A result that the model starts before the timer expires carries an invalid flag. All serial pins are sampled on the system clock, which must run at least four times faster than the serial clock.

Top module: `adc_pm_engine`

## Requirements
- R1: After reset the control register reads 12'h0C0 (active mode), the part is powered and tracking, the output enable is low and the shadow register is zero.
- R2: The data output enable rises one system clock after chip select falls, in any state except full power-down. It is low by the first clock edge after chip select rises.
- R3: The result frame is 0, then the channel field held at the chip-select falling edge (MSB first), then the 12-bit sample (MSB first). The first bit appears when chip select falls, and each later bit follows one serial-clock falling edge.
- R4: The command word is sampled MSB first on serial-clock falling edges. Control bit 11 is the write-enable, bits 10:8 are the channel and bits 7:6 are the power mode (PM1, PM0). A frame that completes 16 edges with write-enable 1 loads the control register from the first 12 bits and the shadow register from all 16.
- R5: A complete frame with write-enable 0 changes neither register.
- R6: A frame that chip select ends before 16 falling edges updates no register and leaves the power state as it was.
- R7: Power mode 2'b10 puts the part in full power-down: not powered, track/hold in hold. It stays there until a complete frame leaves a different mode in the control register.
- R8: A frame started in full power-down never drives the output. Its track/hold returns to track on the 14th serial-clock falling edge.
- R9: After a wake begins, the powered indication rises exactly PWRUP_CYC system clocks later.
- R10: Power mode 2'b01 puts the part in hold at the end of every complete frame. The next chip-select falling edge returns it to track and starts the power-up timer.
- R11: The invalid flag is high for a frame whose chip select fell while the part was not powered, and low otherwise.
- R12: Power mode 2'b00 acts as active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial command data |
| sample_i | input | RES_BITS | Modelled conversion value |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable; low means tri-stated |
| track_o | output | 1 | 1 = track/hold tracking, 0 = hold |
| pwr_ok_o | output | 1 | Part fully powered |
| conv_invalid_o | output | 1 | Result of current frame flagged invalid |
| ctrl_o | output | CTRL_BITS | Control register |
| shadow_o | output | 1+CHAN_BITS+RES_BITS | Shadow register |

## Verification
A wrong power state shows up at the ports at once: the powered and track indications do not match the mode written. It also shows up no later than the next frame, as a driven output when the output should be tri-stated, or as a wrong invalid flag. If the bit counter or the shift registers slip, the channel tag and the result bits move by whole positions within that same frame. A slip also leaves a wrong control word one frame later, when the next result carries the wrong channel field. A timer that is off by even one cycle is caught by sampling the powered indication on the cycle just before the wake ends and on the cycle when it ends.

// File: rtl/adcpm_pkg.sv
package adcpm_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_WAKE   = 2'd1,
    PS_FULL   = 2'd2,
    PS_AUTO   = 2'd3
  } pwr_state_e;

  localparam logic [1:0] PM_FULL = 2'b10;
  localparam logic [1:0] PM_AUTO = 2'b01;
endpackage

// File: rtl/adcpm_edges.sv
module adcpm_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_fall_o
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
    end
  end

  always_comb begin
    cs_fall_o   = cs_q & ~cs_n_i;
    cs_rise_o   = ~cs_q & cs_n_i;
    sclk_fall_o = sclk_q & ~sclk_i & ~cs_n_i;
  end
endmodule

// File: rtl/adcpm_shifter.sv
module adcpm_shifter #(
  parameter int FRAME_BITS = 16,
  parameter int TRACK_EDGE = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall_i,
  input  logic                  cs_rise_i,
  input  logic                  sclk_fall_i,
  input  logic                  din_i,
  input  logic [FRAME_BITS-1:0] load_word_i,
  output logic [FRAME_BITS-1:0] cmd_o,
  output logic                  dout_o,
  output logic                  done_o,
  output logic                  abort_o,
  output logic                  track_edge_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_TRK  = CNT_W'(TRACK_EDGE - 1);

  logic                  in_frame_q, in_frame_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] in_sr_q, in_sr_d;
  logic [FRAME_BITS-1:0] out_sr_q, out_sr_d;
  logic                  bit_en;

  always_comb begin
    bit_en     = sclk_fall_i & in_frame_q & (cnt_q < CNT_FULL);
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    in_sr_d    = in_sr_q;
    out_sr_d   = out_sr_q;
    if (cs_fall_i) begin
      in_frame_d = 1'b1;
      cnt_d      = '0;
      out_sr_d   = load_word_i;
    end else if (bit_en) begin
      cnt_d    = cnt_q + 1'b1;
      in_sr_d  = {in_sr_q[FRAME_BITS-2:0], din_i};
      out_sr_d = {out_sr_q[FRAME_BITS-2:0], 1'b0};
    end
    if (cs_rise_i) in_frame_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      in_sr_q    <= '0;
      out_sr_q   <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
      in_sr_q    <= in_sr_d;
      out_sr_q   <= out_sr_d;
    end
  end

  always_comb begin
    cmd_o        = in_sr_q;
    dout_o       = out_sr_q[FRAME_BITS-1];
    done_o       = cs_rise_i & in_frame_q & (cnt_q == CNT_FULL);
    abort_o      = cs_rise_i & in_frame_q & (cnt_q != CNT_FULL);
    track_edge_o = bit_en & (cnt_q == CNT_TRK);
  end

  // R4: bit count never passes the frame length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R6: a short frame never reports completion
  p_abort_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !done_o);
endmodule

// File: rtl/adcpm_power.sv
module adcpm_power
  import adcpm_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CTRL_BITS  = 12,
  parameter int CHAN_BITS  = 3,
  parameter int PWRUP_CYC  = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall_i,
  input  logic                  cs_rise_i,
  input  logic                  done_i,
  input  logic                  abort_i,
  input  logic                  track_edge_i,
  input  logic [FRAME_BITS-1:0] cmd_i,
  output logic [CTRL_BITS-1:0]  ctrl_o,
  output logic [FRAME_BITS-1:0] shadow_o,
  output logic [CHAN_BITS-1:0]  chan_o,
  output logic                  oe_o,
  output logic                  track_o,
  output logic                  pwr_ok_o,
  output logic                  invalid_o
);
  localparam int WR_POS = CTRL_BITS - 1;
  localparam int CH_HI  = CTRL_BITS - 2;
  localparam int CH_LO  = CTRL_BITS - 1 - CHAN_BITS;
  localparam int PM_HI  = CH_LO - 1;
  localparam int PM_LO  = CH_LO - 2;
  localparam int TMR_W  = $clog2(PWRUP_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PWRUP_CYC - 1);
  localparam logic [CTRL_BITS-1:0] CTRL_RST =
    {{(CTRL_BITS-2){1'b0}}, 2'b11} << PM_LO;

  pwr_state_e            st_q, st_d;
  logic [TMR_W-1:0]      tmr_q, tmr_d;
  logic [CTRL_BITS-1:0]  ctrl_q, ctrl_d, new_ctrl;
  logic [FRAME_BITS-1:0] shadow_q, shadow_d;
  logic                  hold_q, hold_d;
  logic                  oe_q, oe_d;
  logic                  quiet_q, quiet_d;
  logic                  inv_q, inv_d;
  logic                  wr_en;
  logic [1:0]            new_pm;

  always_comb begin
    wr_en    = cmd_i[FRAME_BITS-1-(CTRL_BITS-1-WR_POS)];
    new_ctrl = wr_en ? cmd_i[FRAME_BITS-1 -: CTRL_BITS] : ctrl_q;
    new_pm   = new_ctrl[PM_HI:PM_LO];
    st_d     = st_q;
    tmr_d    = tmr_q;
    ctrl_d   = ctrl_q;
    shadow_d = shadow_q;
    hold_d   = hold_q;
    oe_d     = oe_q;
    quiet_d  = quiet_q;
    inv_d    = inv_q;

    if (st_q == PS_WAKE) begin
      if (tmr_q == '0) st_d = PS_ACTIVE;
      else             tmr_d = tmr_q - 1'b1;
    end

    if (cs_fall_i) begin
      inv_d   = (st_q != PS_ACTIVE);
      oe_d    = (st_q != PS_FULL);
      quiet_d = (st_q == PS_FULL);
      if (st_q == PS_AUTO) begin
        st_d   = PS_WAKE;
        tmr_d  = TMR_LOAD;
        hold_d = 1'b0;
      end
    end

    if (track_edge_i && quiet_q) hold_d = 1'b0;

    if (cs_rise_i) begin
      oe_d    = 1'b0;
      quiet_d = 1'b0;
    end

    if (abort_i && st_q == PS_FULL) hold_d = 1'b1;

    if (done_i) begin
      ctrl_d = new_ctrl;
      if (wr_en) shadow_d = cmd_i;
      case (new_pm)
        PM_FULL: begin
          st_d   = PS_FULL;
          hold_d = 1'b1;
        end
        PM_AUTO: begin
          st_d   = PS_AUTO;
          hold_d = 1'b1;
        end
        default: begin
          if (st_q == PS_FULL) begin
            st_d   = PS_WAKE;
            tmr_d  = TMR_LOAD;
            hold_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_ACTIVE;
      tmr_q    <= '0;
      ctrl_q   <= CTRL_RST;
      shadow_q <= '0;
      hold_q   <= 1'b0;
      oe_q     <= 1'b0;
      quiet_q  <= 1'b0;
      inv_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      tmr_q    <= tmr_d;
      ctrl_q   <= ctrl_d;
      shadow_q <= shadow_d;
      hold_q   <= hold_d;
      oe_q     <= oe_d;
      quiet_q  <= quiet_d;
      inv_q    <= inv_d;
    end
  end

  always_comb begin
    ctrl_o    = ctrl_q;
    shadow_o  = shadow_q;
    chan_o    = ctrl_q[CH_HI:CH_LO];
    oe_o      = oe_q;
    track_o   = ~hold_q;
    pwr_ok_o  = (st_q == PS_ACTIVE);
    invalid_o = inv_q;
  end

  // checker: length of the current wake interval
  logic [TMR_W:0] wake_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_len <= '0;
    else        wake_len <= (st_q == PS_WAKE) ? wake_len + 1'b1 : '0;
  end

  // R9: a wake never outlasts the timer setting
  p_wake_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_WAKE) |-> (int'(wake_len) < PWRUP_CYC));
  // R9: leaving wake happens exactly at the timer setting
  p_wake_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PS_WAKE && st_q == PS_ACTIVE) |-> (int'(wake_len) == PWRUP_CYC));
  // R4: a written complete frame lands in the control register
  p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && wr_en) |=> (ctrl_q == $past(cmd_i[FRAME_BITS-1 -: CTRL_BITS])));
  // R5: write-enable low leaves both registers alone
  p_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !wr_en) |=> ($stable(ctrl_q) && $stable(shadow_q)));
  // R6: a short frame leaves the registers alone
  p_abort_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> ($stable(ctrl_q) && $stable(shadow_q)));
  // R7: full power-down persists until a frame completes
  p_full_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_FULL && !done_i) |=> (st_q == PS_FULL));
  // R8: a frame opened in full power-down is not driven
  p_quiet_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall_i && st_q == PS_FULL) |=> !oe_q);
  // R10: auto power-down wakes on chip-select fall
  p_auto_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall_i && st_q == PS_AUTO) |=> (st_q == PS_WAKE && !hold_q));
endmodule

// File: rtl/adc_pm_engine.sv
module adc_pm_engine #(
  parameter int CTRL_BITS  = 12,
  parameter int CHAN_BITS  = 3,
  parameter int RES_BITS   = 12,
  parameter int TRACK_EDGE = 14,
  parameter int PWRUP_CYC  = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n_i,
  input  logic                        sclk_i,
  input  logic                        din_i,
  input  logic [RES_BITS-1:0]         sample_i,
  output logic                        dout_o,
  output logic                        dout_oe_o,
  output logic                        track_o,
  output logic                        pwr_ok_o,
  output logic                        conv_invalid_o,
  output logic [CTRL_BITS-1:0]        ctrl_o,
  output logic [CHAN_BITS+RES_BITS:0] shadow_o
);
  localparam int FRAME_BITS = 1 + CHAN_BITS + RES_BITS;

  logic                  cs_fall, cs_rise, sclk_fall;
  logic                  done, abort, track_edge;
  logic [FRAME_BITS-1:0] cmd, load_word;
  logic [CHAN_BITS-1:0]  chan;

  adcpm_edges u_edges (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .sclk_i      (sclk_i),
    .cs_fall_o   (cs_fall),
    .cs_rise_o   (cs_rise),
    .sclk_fall_o (sclk_fall)
  );

  assign load_word = {1'b0, chan, sample_i};

  adcpm_shifter #(
    .FRAME_BITS (FRAME_BITS),
    .TRACK_EDGE (TRACK_EDGE)
  ) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_fall_i    (cs_fall),
    .cs_rise_i    (cs_rise),
    .sclk_fall_i  (sclk_fall),
    .din_i        (din_i),
    .load_word_i  (load_word),
    .cmd_o        (cmd),
    .dout_o       (dout_o),
    .done_o       (done),
    .abort_o      (abort),
    .track_edge_o (track_edge)
  );

  adcpm_power #(
    .FRAME_BITS (FRAME_BITS),
    .CTRL_BITS  (CTRL_BITS),
    .CHAN_BITS  (CHAN_BITS),
    .PWRUP_CYC  (PWRUP_CYC)
  ) u_power (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_fall_i    (cs_fall),
    .cs_rise_i    (cs_rise),
    .done_i       (done),
    .abort_i      (abort),
    .track_edge_i (track_edge),
    .cmd_i        (cmd),
    .ctrl_o       (ctrl_o),
    .shadow_o     (shadow_o),
    .chan_o       (chan),
    .oe_o         (dout_oe_o),
    .track_o      (track_o),
    .pwr_ok_o     (pwr_ok_o),
    .invalid_o    (conv_invalid_o)
  );

  // R2: output released while chip select stays high
  p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i)) |-> !dout_oe_o);
  // R3: every frame opens with the zero start bit
  p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !dout_o);
endmodule

// File: tb/tb_adc_pm_engine.sv
module tb_adc_pm_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP      = 40;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din;
  logic [11:0] sample;
  logic        dout, dout_oe, track, pwr_ok, inv;
  logic [11:0] ctrl;
  logic [15:0] shadow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] word;
    logic        oe;
    logic        inv;
    logic        chkdata;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] obs_word;
  logic        obs_oe, obs_inv, obs_trk0, obs_trk13, obs_trk14;
  event        frame_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pm_engine #(.PWRUP_CYC(PWRUP)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .sample_i(sample), .dout_o(dout), .dout_oe_o(dout_oe), .track_o(track),
    .pwr_ok_o(pwr_ok), .conv_invalid_o(inv), .ctrl_o(ctrl), .shadow_o(shadow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_frame(input logic [15:0] cmd, input int nclk, input exp_t e);
    exp_q.push_back(e);
    obs_word = '0;
    @(negedge clk);
    cs_n = 1'b0;
    waitn(2);
    obs_word[15] = dout;
    obs_oe   = dout_oe;
    obs_trk0 = track;
    for (int i = 1; i <= nclk; i++) begin
      sclk = 1'b0;
      din  = cmd[16-i];
      waitn(2);
      if (i < 16) obs_word[15-i] = dout;
      if (i == 13) obs_trk13 = track;
      if (i == 14) obs_trk14 = track;
      obs_inv = inv;
      sclk = 1'b1;
      waitn(2);
    end
    cs_n = 1'b1;
    waitn(1);
    -> frame_ev;
    waitn(1);
  endtask

  initial begin : monitor
    forever begin
      @(frame_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected frame", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(obs_oe === e.oe, "R2", {e.tag, " oe"}, obs_oe, e.oe);
        chk(obs_inv === e.inv, "R11", {e.tag, " invalid"}, obs_inv, e.inv);
        if (e.chkdata)
          chk(obs_word === e.word, "R3", {e.tag, " word"}, obs_word, e.word);
      end
    end
  end

  function automatic exp_t mk(input logic [15:0] w, input logic oe,
                              input logic iv, input logic cd, input string t);
    exp_t e;
    e.word = w; e.oe = oe; e.inv = iv; e.chkdata = cd; e.tag = t;
    return e;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0; sample = '0;
    waitn(5);
    rst_n = 1'b1;
    waitn(2);
    // R1 reset state
    chk(ctrl === 12'h0C0, "R1", "ctrl", ctrl, 12'h0C0);
    chk(pwr_ok === 1'b1 && track === 1'b1, "R1", "pwr/track", {pwr_ok, track}, 2'b11);
    chk(dout_oe === 1'b0, "R1", "oe", dout_oe, 0);
    chk(shadow === 16'h0, "R1", "shadow", shadow, 0);

    // R4 write chan 5, mode 11
    sample = 12'hABC;
    run_frame(16'hDEAF, 16, mk(16'h0ABC, 1, 0, 1, "F1"));
    chk(ctrl === 12'hDEA, "R4", "ctrl load", ctrl, 12'hDEA);
    chk(shadow === 16'hDEAF, "R4", "shadow load", shadow, 16'hDEAF);
    chk(dout_oe === 1'b0, "R2", "oe after frame", dout_oe, 0);

    // R5 write-enable low
    sample = 12'h123;
    run_frame(16'h1234, 16, mk(16'h5123, 1, 0, 1, "F2"));
    chk(ctrl === 12'hDEA, "R5", "ctrl kept", ctrl, 12'hDEA);
    chk(shadow === 16'hDEAF, "R5", "shadow kept", shadow, 16'hDEAF);

    // R6 short frame
    run_frame(16'hA800, 10, mk(16'h0, 1, 0, 0, "F3"));
    chk(ctrl === 12'hDEA, "R6", "ctrl after abort", ctrl, 12'hDEA);
    chk(pwr_ok === 1'b1, "R6", "pwr after abort", pwr_ok, 1);

    // R12 mode 00
    sample = 12'h3C5;
    run_frame(16'hD000, 16, mk(16'h53C5, 1, 0, 1, "F4"));
    chk(ctrl === 12'hD00, "R12", "ctrl", ctrl, 12'hD00);
    chk(pwr_ok === 1'b1 && track === 1'b1, "R12", "still active", {pwr_ok, track}, 2'b11);

    // R7 full power-down, chan 3
    sample = 12'h001;
    run_frame(16'hB800, 16, mk(16'h5001, 1, 0, 1, "F5"));
    chk(pwr_ok === 1'b0 && track === 1'b0, "R7", "full down", {pwr_ok, track}, 2'b00);

    // R8 frame in full power-down without write
    run_frame(16'h0000, 16, mk(16'h0, 0, 1, 0, "F6"));
    chk(obs_trk13 === 1'b0, "R8", "hold before edge 14", obs_trk13, 0);
    chk(obs_trk14 === 1'b1, "R8", "track at edge 14", obs_trk14, 1);
    chk(pwr_ok === 1'b0 && track === 1'b0, "R7", "stays down", {pwr_ok, track}, 2'b00);

    // R8 wake frame, then R11 early conversion
    run_frame(16'hBC00, 16, mk(16'h0, 0, 1, 0, "F7"));
    chk(obs_trk14 === 1'b1, "R8", "wake track edge 14", obs_trk14, 1);
    chk(pwr_ok === 1'b0, "R9", "not yet powered", pwr_ok, 0);
    sample = 12'h777;
    run_frame(16'h0000, 16, mk(16'h3777, 1, 1, 1, "F8"));
    chk(pwr_ok === 1'b1, "R9", "powered after frame", pwr_ok, 1);

    // R9 exact timer
    run_frame(16'hB800, 16, mk(16'h3777, 1, 0, 1, "F9"));
    run_frame(16'hBC00, 16, mk(16'h0, 0, 1, 0, "F10"));
    // the frame task ended one clock after the start edge
    waitn(PWRUP - 2);
    chk(pwr_ok === 1'b0, "R9", "one cycle early", pwr_ok, 0);
    waitn(1);
    chk(pwr_ok === 1'b1, "R9", "on time", pwr_ok, 1);
    sample = 12'h5A5;
    run_frame(16'h0000, 16, mk(16'h35A5, 1, 0, 1, "F11"));

    // R10 auto power-down
    sample = 12'h0F0;
    run_frame(16'hB400, 16, mk(16'h30F0, 1, 0, 1, "F12"));
    chk(pwr_ok === 1'b0 && track === 1'b0, "R10", "auto down", {pwr_ok, track}, 2'b00);
    sample = 12'h9C3;
    run_frame(16'h0000, 16, mk(16'h39C3, 1, 1, 1, "F13"));
    chk(obs_trk0 === 1'b1, "R10", "track on cs fall", obs_trk0, 1);
    chk(pwr_ok === 1'b0 && track === 1'b0, "R10", "down again", {pwr_ok, track}, 2'b00);
    sample = 12'h111;
    run_frame(16'hBC00, 16, mk(16'h3111, 1, 1, 1, "F14"));
    chk(pwr_ok === 1'b1 && track === 1'b1, "R10", "back active", {pwr_ok, track}, 2'b11);
    sample = 12'h246;
    run_frame(16'h0000, 16, mk(16'h3246, 1, 0, 1, "F15"));
    chk(exp_q.size() == 0, "R3", "all frames seen", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule